// File: doc/BRIEF.md
# LPC bus I/O target

This block sits on the peripheral side of a four-bit multiplexed LPC bus and responds to single-byte I/O reads and writes from the host. It follows the frame strobe and the nibble lines one bus clock at a time. It records the cycle kind and the 16-bit I/O address, then compares the upper address bits against a base supplied on `cfg_base`. A matching cycle gives the low address bits to a small local register port. The target then runs its side of the bus handshake: it keeps off the lines during the host's turn, drives a status nibble for as long as the local side needs, returns read data, and gives the lines back to the host.

The local side sees a one-cycle read or write strobe together with the offset and the write byte. It answers with a ready level, and optionally an error level, in the same cycle or any later cycle. On the bus side the block produces a nibble and an output enable for an external tri-state buffer. Cycles that do not match, cycles of an unsupported kind and cycles with a non-standard start code leave the lines undriven, so the host sees the pulled-up value and times out. A long frame-low period that ends with the abort code clears any cycle in progress.

Top module: `lpc_io_target`

## Requirements
- R1: While `rst_n` is low, `bus_nib_oe`, `loc_wr` and `loc_rd` are low, and the target leaves reset in its idle state.
- R2: A cycle is accepted when the nibble on the last frame-low cycle is 0000, the nibble on the first frame-high cycle is 0000 (I/O read) or 0010 (I/O write), and the following four nibbles, most significant first, form an address whose bits [15:WIN_W] equal those of `cfg_base`. `loc_addr` then carries address bits [WIN_W-1:0].
- R3: For a write, the two nibbles after the address form the byte, low nibble first. That byte is on `loc_wdata` when `loc_wr` pulses high, and the pulse falls in the second host turn-around cycle.
- R4: During the two host turn-around cycles after the last address or write-data nibble, `bus_nib_oe` is low. The target drives first in the cycle after them.
- R5: After the turn-around the target drives 0110 in every cycle in which the local side has not yet raised `loc_ready`. It then drives exactly one final nibble: 1010 if `loc_err` was high when ready was taken, otherwise 0000.
- R6: For a read, the two cycles after the final status nibble carry `loc_rdata` as sampled when ready was taken, low nibble first, with the output enabled.
- R7: After the final status nibble of a write, or after the read data, the target drives 1111 for one cycle and then releases the lines.
- R8: A cycle whose address misses the base window produces no strobe and never enables the output. The bus stays at 1111, and local storage is untouched.
- R9: A start nibble other than 0000, or a kind nibble other than 0000 or 0010, is ignored in the same way as R8.
- R10: The frame strobe going low releases the lines from the next cycle on. After four or more low cycles ending with start 1111, the target stays idle until a new frame, and a following valid cycle is served normally.
- R11: `loc_wr` and `loc_rd` are never high together, and each one is a single-cycle pulse per accepted cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_frame_n | input | 1 | Active-low frame strobe from the host |
| bus_nib_in | input | 4 | Value currently on the nibble lines |
| bus_nib_out | output | 4 | Nibble the target drives |
| bus_nib_oe | output | 1 | Output enable for the nibble lines |
| cfg_base | input | ADDR_W | Base I/O address; bits [WIN_W-1:0] are ignored |
| loc_addr | output | WIN_W | Register offset inside the window |
| loc_wdata | output | 8 | Write byte for the local register |
| loc_wr | output | 1 | One-cycle local write strobe |
| loc_rd | output | 1 | One-cycle local read strobe |
| loc_rdata | input | 8 | Read byte from the local register |
| loc_ready | input | 1 | Local access complete |
| loc_err | input | 1 | Local access failed; sampled with ready |

## Verification
A wrong phase counter or a wrong state moves the first driven cycle, or the first status nibble, by one or more clocks. The bench looks at the lines in every cycle after the host's turn-around, so such a shift shows up within one cycle of the point where the bus is handed to the target. Errors in the address shift or in the window compare show up as a strobe on the wrong offset, or as a missing strobe, in the second turn-around cycle. A write to the wrong offset is caught later, when the full window is read back and compared with a model computed in the bench.

// File: rtl/lpc_io_pkg.sv
package lpc_io_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WDATA,
    ST_TURN_IN,
    ST_WAIT,
    ST_ACK,
    ST_RDATA,
    ST_TURN_OUT
  } io_state_e;

  localparam logic [3:0] NIB_START_STD  = 4'h0;
  localparam logic [3:0] NIB_ABORT      = 4'hF;
  localparam logic [3:0] NIB_HS_WAIT    = 4'h6;
  localparam logic [3:0] NIB_HS_READY   = 4'h0;
  localparam logic [3:0] NIB_HS_ERROR   = 4'hA;
  localparam logic [3:0] NIB_PULLED     = 4'hF;

  // Kind nibble: [3:2] = transfer type (00 = I/O), [1] = write, [0] reserved zero.
  function automatic logic kind_supported(input logic [3:0] kind);
    return (kind[3:2] == 2'b00) && !kind[0];
  endfunction

  function automatic logic kind_is_write(input logic [3:0] kind);
    return kind[1];
  endfunction

  function automatic logic [3:0] hs_final(input logic err);
    return err ? NIB_HS_ERROR : NIB_HS_READY;
  endfunction

endpackage

// File: rtl/lpc_frame_track.sv
module lpc_frame_track
  import lpc_io_pkg::*;
#(
  parameter int ABORT_MIN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_n,
  input  logic [3:0] nib_in,
  output logic       kind_slot,
  output logic       start_std,
  output logic       abort_evt
);

  localparam int LC_W = $clog2(ABORT_MIN + 1);

  logic            prev_low;
  logic [3:0]      start_q;
  logic [LC_W-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_low <= 1'b0;
      start_q  <= NIB_PULLED;
      low_cnt  <= '0;
    end else begin
      prev_low <= !frame_n;
      if (!frame_n) begin
        start_q <= nib_in;
        if (low_cnt != LC_W'(ABORT_MIN)) low_cnt <= low_cnt + 1'b1;
      end else begin
        low_cnt <= '0;
      end
    end
  end

  // First high cycle after a low period: the kind nibble is on the lines.
  assign kind_slot = frame_n && prev_low;
  assign start_std = (start_q == NIB_START_STD);
  assign abort_evt = kind_slot && (start_q == NIB_ABORT) && (low_cnt == LC_W'(ABORT_MIN));

endmodule

// File: rtl/lpc_io_fsm.sv
module lpc_io_fsm
  import lpc_io_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WIN_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic [3:0]        nib_in,
  input  logic              kind_slot,
  input  logic              start_std,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic              loc_ready,
  input  logic              loc_err,
  input  logic [7:0]        loc_rdata,
  output io_state_e         state,
  output logic              phase_second,
  output logic              err_q,
  output logic [7:0]        rdata_q,
  output logic [WIN_W-1:0]  loc_addr,
  output logic [7:0]        loc_wdata,
  output logic              loc_wr,
  output logic              loc_rd
);

  localparam int ADDR_NIBS = ADDR_W / 4;
  localparam int CNT_W     = (ADDR_NIBS > 2) ? $clog2(ADDR_NIBS) : 1;

  logic [CNT_W-1:0]  cnt;
  logic              is_wr;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wdata_q;
  logic [ADDR_W-1:0] addr_next;
  logic              addr_last;
  logic              strobe;
  logic              take_ready;

  function automatic logic in_window(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] b);
    return a[ADDR_W-1:WIN_W] == b[ADDR_W-1:WIN_W];
  endfunction

  assign addr_next    = {addr_q[ADDR_W-5:0], nib_in};
  assign addr_last    = (cnt == CNT_W'(ADDR_NIBS - 1));
  assign phase_second = (cnt == CNT_W'(1));
  assign strobe       = (state == ST_TURN_IN) && phase_second && frame_n;
  assign take_ready   = loc_ready && (strobe || (state == ST_WAIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      is_wr   <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (!frame_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (kind_slot && start_std && kind_supported(nib_in)) begin
            is_wr <= kind_is_write(nib_in);
            state <= ST_ADDR;
          end
        end
        ST_ADDR: begin
          addr_q <= addr_next;
          if (addr_last) begin
            cnt <= '0;
            if (in_window(addr_next, cfg_base)) state <= is_wr ? ST_WDATA : ST_TURN_IN;
            else                                state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WDATA: begin
          if (!phase_second) begin
            wdata_q[3:0] <= nib_in;
            cnt          <= cnt + 1'b1;
          end else begin
            wdata_q[7:4] <= nib_in;
            cnt          <= '0;
            state        <= ST_TURN_IN;
          end
        end
        ST_TURN_IN: begin
          if (!phase_second) begin
            cnt <= cnt + 1'b1;
          end else begin
            cnt   <= '0;
            state <= take_ready ? ST_ACK : ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (take_ready) state <= ST_ACK;
        end
        ST_ACK: begin
          cnt   <= '0;
          state <= is_wr ? ST_TURN_OUT : ST_RDATA;
        end
        ST_RDATA: begin
          if (!phase_second) begin
            cnt <= cnt + 1'b1;
          end else begin
            cnt   <= '0;
            state <= ST_TURN_OUT;
          end
        end
        ST_TURN_OUT: begin
          if (!phase_second) begin
            cnt <= cnt + 1'b1;
          end else begin
            cnt   <= '0;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (take_ready) begin
        err_q   <= loc_err;
        rdata_q <= loc_rdata;
      end
    end
  end

  assign loc_wr    = strobe && is_wr;
  assign loc_rd    = strobe && !is_wr;
  assign loc_addr  = addr_q[WIN_W-1:0];
  assign loc_wdata = wdata_q;

endmodule

// File: rtl/lpc_nib_drive.sv
module lpc_nib_drive
  import lpc_io_pkg::*;
(
  input  io_state_e  state,
  input  logic       phase_second,
  input  logic       err_q,
  input  logic [7:0] rdata_q,
  output logic [3:0] nib_out,
  output logic       nib_oe
);

  always_comb begin
    nib_oe  = 1'b0;
    nib_out = NIB_PULLED;
    case (state)
      ST_WAIT: begin
        nib_oe  = 1'b1;
        nib_out = NIB_HS_WAIT;
      end
      ST_ACK: begin
        nib_oe  = 1'b1;
        nib_out = hs_final(err_q);
      end
      ST_RDATA: begin
        nib_oe  = 1'b1;
        nib_out = phase_second ? rdata_q[7:4] : rdata_q[3:0];
      end
      ST_TURN_OUT: begin
        nib_oe  = !phase_second;
        nib_out = NIB_PULLED;
      end
      default: begin
        nib_oe  = 1'b0;
        nib_out = NIB_PULLED;
      end
    endcase
  end

endmodule

// File: rtl/lpc_io_target.sv
module lpc_io_target
  import lpc_io_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int WIN_W     = 3,
  parameter int ABORT_MIN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_frame_n,
  input  logic [3:0]        bus_nib_in,
  output logic [3:0]        bus_nib_out,
  output logic              bus_nib_oe,
  input  logic [ADDR_W-1:0] cfg_base,
  output logic [WIN_W-1:0]  loc_addr,
  output logic [7:0]        loc_wdata,
  output logic              loc_wr,
  output logic              loc_rd,
  input  logic [7:0]        loc_rdata,
  input  logic              loc_ready,
  input  logic              loc_err
);

  io_state_e  state;
  logic       phase_second;
  logic       err_q;
  logic [7:0] rdata_q;
  logic       kind_slot;
  logic       start_std;
  logic       abort_evt;

  // Named events for the bound checker.
  logic hs_phase;
  logic hs_wait;
  logic turn_in_phase;

  lpc_frame_track #(
    .ABORT_MIN(ABORT_MIN)
  ) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_n  (bus_frame_n),
    .nib_in   (bus_nib_in),
    .kind_slot(kind_slot),
    .start_std(start_std),
    .abort_evt(abort_evt)
  );

  lpc_io_fsm #(
    .ADDR_W(ADDR_W),
    .WIN_W (WIN_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_n     (bus_frame_n),
    .nib_in      (bus_nib_in),
    .kind_slot   (kind_slot),
    .start_std   (start_std),
    .cfg_base    (cfg_base),
    .loc_ready   (loc_ready),
    .loc_err     (loc_err),
    .loc_rdata   (loc_rdata),
    .state       (state),
    .phase_second(phase_second),
    .err_q       (err_q),
    .rdata_q     (rdata_q),
    .loc_addr    (loc_addr),
    .loc_wdata   (loc_wdata),
    .loc_wr      (loc_wr),
    .loc_rd      (loc_rd)
  );

  lpc_nib_drive u_drive (
    .state       (state),
    .phase_second(phase_second),
    .err_q       (err_q),
    .rdata_q     (rdata_q),
    .nib_out     (bus_nib_out),
    .nib_oe      (bus_nib_oe)
  );

  assign hs_phase      = (state == ST_WAIT) || (state == ST_ACK);
  assign hs_wait       = (state == ST_WAIT);
  assign turn_in_phase = (state == ST_TURN_IN);

endmodule

// File: rtl/lpc_io_target_chk.sv
module lpc_io_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_n,
  input logic       nib_oe,
  input logic [3:0] nib_out,
  input logic       loc_wr,
  input logic       loc_rd,
  input logic       loc_ready,
  input logic       hs_phase,
  input logic       hs_wait,
  input logic       turn_in_phase,
  input logic       abort_evt
);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!nib_oe && !loc_wr && !loc_rd));

  a_r11_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(loc_wr && loc_rd));

  a_r11_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_wr || loc_rd) |=> !(loc_wr || loc_rd));

  a_r10_frame_release: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> !nib_oe);

  a_r10_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |-> !nib_oe);

  a_r4_drive_after_turn: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nib_oe) |-> $past(turn_in_phase));

  a_r5_hs_codes: assert property (@(posedge clk) disable iff (!rst_n)
    hs_phase |-> (nib_oe && (nib_out == 4'h6 || nib_out == 4'h0 || nib_out == 4'hA)));

  a_r5_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_wait && !loc_ready && frame_n) |=> (nib_oe && nib_out == 4'h6));

  a_r5_final_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_wait && loc_ready && frame_n) |=> (nib_oe && (nib_out == 4'h0 || nib_out == 4'hA)));

endmodule

bind lpc_io_target lpc_io_target_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_n      (bus_frame_n),
  .nib_oe       (bus_nib_oe),
  .nib_out      (bus_nib_out),
  .loc_wr       (loc_wr),
  .loc_rd       (loc_rd),
  .loc_ready    (loc_ready),
  .hs_phase     (hs_phase),
  .hs_wait      (hs_wait),
  .turn_in_phase(turn_in_phase),
  .abort_evt    (abort_evt)
);

// File: tb/lpc_io_target_tb.sv
module lpc_io_target_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 16;
  localparam int WIN_W      = 3;
  localparam int WIN_N      = 1 << WIN_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic              host_frame_n = 1'b1;
  logic              host_drv = 1'b0;
  logic [3:0]        host_nib = 4'hF;
  logic [ADDR_W-1:0] cfg_base = 16'h02E8;

  logic [3:0]       nib_out;
  logic             nib_oe;
  logic [WIN_W-1:0] loc_addr;
  logic [7:0]       loc_wdata;
  logic             loc_wr;
  logic             loc_rd;
  logic [7:0]       loc_rdata;
  logic             loc_ready;
  logic             tb_err = 1'b0;
  int               tb_wait = 0;

  wire [3:0] bus = nib_oe ? nib_out : (host_drv ? host_nib : 4'hF);

  // Local register model with a programmable number of wait cycles.
  logic [7:0] mem [WIN_N];
  logic       busy;
  int         bcnt;

  function automatic logic [7:0] init_val(input int i);
    return 8'(8'h11 + i * 8'h29);
  endfunction

  assign loc_rdata = mem[loc_addr];
  assign loc_ready = ((loc_wr || loc_rd) && tb_wait == 0) || (busy && bcnt == 0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      bcnt <= 0;
      for (int i = 0; i < WIN_N; i++) mem[i] <= init_val(i);
    end else begin
      if (loc_wr) mem[loc_addr] <= loc_wdata;
      if ((loc_wr || loc_rd) && tb_wait != 0) begin
        busy <= 1'b1;
        bcnt <= tb_wait - 1;
      end else if (busy) begin
        if (bcnt == 0) busy <= 1'b0;
        else           bcnt <= bcnt - 1;
      end
    end
  end

  lpc_io_target #(
    .ADDR_W(ADDR_W),
    .WIN_W (WIN_W)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_frame_n(host_frame_n),
    .bus_nib_in (bus),
    .bus_nib_out(nib_out),
    .bus_nib_oe (nib_oe),
    .cfg_base   (cfg_base),
    .loc_addr   (loc_addr),
    .loc_wdata  (loc_wdata),
    .loc_wr     (loc_wr),
    .loc_rd     (loc_rd),
    .loc_rdata  (loc_rdata),
    .loc_ready  (loc_ready),
    .loc_err    (tb_err)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_mem [WIN_N];

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic hcyc(input logic fr, input logic [3:0] n);
    host_frame_n = fr;
    host_drv     = 1'b1;
    host_nib     = n;
    @(negedge clk);
  endtask

  task automatic io_txn(input logic [3:0] start, input logic [3:0] kind, input logic [15:0] addr,
                        input logic [7:0] wd, input int wait_n, input logic err, input bit hit,
                        input string tag);
    bit         is_wr = (kind == 4'h2);
    logic [7:0] got;
    tb_wait = wait_n;
    tb_err  = err;
    hcyc(1'b0, start);
    hcyc(1'b1, kind);
    for (int i = 3; i >= 0; i--) hcyc(1'b1, addr[i*4 +: 4]);
    if (is_wr) begin
      hcyc(1'b1, wd[3:0]);
      hcyc(1'b1, wd[7:4]);
    end
    // Host turn-around, first cycle: host forces 1111.
    host_drv = 1'b1; host_nib = 4'hF;
    #1 chk(!nib_oe, "R4", 16'(nib_oe), 16'h0);
    @(negedge clk);
    // Second cycle: released; strobe appears here.
    host_drv = 1'b0;
    #1 chk(!nib_oe, "R4", 16'(nib_oe), 16'h0);
    chk(loc_wr == (hit && is_wr), hit ? "R3" : tag, 16'(loc_wr), 16'(hit && is_wr));
    chk(loc_rd == (hit && !is_wr), hit ? "R11" : tag, 16'(loc_rd), 16'(hit && !is_wr));
    if (hit) chk(loc_addr == addr[WIN_W-1:0], "R2", 16'(loc_addr), 16'(addr[WIN_W-1:0]));
    if (hit && is_wr) chk(loc_wdata == wd, "R3", 16'(loc_wdata), 16'(wd));
    @(negedge clk);
    if (!hit) begin
      for (int k = 0; k < 3; k++) begin
        #1 chk(!nib_oe && bus == 4'hF, tag, {11'd0, nib_oe, bus}, 16'h000F);
        @(negedge clk);
      end
    end else begin
      for (int k = 0; k < wait_n; k++) begin
        #1 chk(nib_oe && bus == 4'h6, "R5", {11'd0, nib_oe, bus}, 16'h0016);
        @(negedge clk);
      end
      #1 chk(nib_oe && bus == (err ? 4'hA : 4'h0), "R5", {11'd0, nib_oe, bus},
             err ? 16'h001A : 16'h0010);
      @(negedge clk);
      if (!is_wr) begin
        #1 got[3:0] = bus;
        chk(nib_oe, "R6", 16'(nib_oe), 16'h1);
        @(negedge clk);
        #1 got[7:4] = bus;
        chk(nib_oe, "R6", 16'(nib_oe), 16'h1);
        @(negedge clk);
        chk(got == exp_mem[addr[WIN_W-1:0]], "R6", 16'(got), 16'(exp_mem[addr[WIN_W-1:0]]));
      end else begin
        exp_mem[addr[WIN_W-1:0]] = wd;
      end
      #1 chk(nib_oe && bus == 4'hF, "R7", {11'd0, nib_oe, bus}, 16'h001F);
      @(negedge clk);
      #1 chk(!nib_oe, "R7", 16'(nib_oe), 16'h0);
      @(negedge clk);
    end
    host_drv = 1'b0;
    host_frame_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < WIN_N; i++) exp_mem[i] = init_val(i);
    repeat (3) @(negedge clk);
    #1 chk(!nib_oe && !loc_wr && !loc_rd, "R1", {13'd0, nib_oe, loc_wr, loc_rd}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    #1 chk(!nib_oe, "R1", 16'(nib_oe), 16'h0);
    @(negedge clk);

    // Write every offset of the window with varied wait and error patterns.
    for (int i = 0; i < WIN_N; i++)
      io_txn(4'h0, 4'h2, cfg_base + 16'(i), 8'(8'h5A + i * 8'h37), i % 3, i == 6, 1'b1, "R2");
    // Read them back.
    for (int i = 0; i < WIN_N; i++)
      io_txn(4'h0, 4'h0, cfg_base + 16'(i), 8'h00, (i + 1) % 4, i == 3, 1'b1, "R2");

    // Address misses just outside the window and far away.
    io_txn(4'h0, 4'h2, cfg_base + 16'd8, 8'hEE, 0, 1'b0, 1'b0, "R8");
    io_txn(4'h0, 4'h2, cfg_base - 16'd1, 8'hEE, 0, 1'b0, 1'b0, "R8");
    io_txn(4'h0, 4'h0, cfg_base ^ 16'h8000, 8'h00, 0, 1'b0, 1'b0, "R8");
    io_txn(4'h0, 4'h2, cfg_base ^ 16'h0100, 8'hEE, 0, 1'b0, 1'b0, "R8");

    // Unsupported kinds and start codes on an in-window address.
    io_txn(4'h0, 4'h4, cfg_base + 16'd1, 8'h00, 0, 1'b0, 1'b0, "R9");
    io_txn(4'h0, 4'h6, cfg_base + 16'd1, 8'h00, 0, 1'b0, 1'b0, "R9");
    io_txn(4'h0, 4'h1, cfg_base + 16'd1, 8'h00, 0, 1'b0, 1'b0, "R9");
    io_txn(4'h5, 4'h0, cfg_base + 16'd1, 8'h00, 0, 1'b0, 1'b0, "R9");
    io_txn(4'hD, 4'h2, cfg_base + 16'd2, 8'hEE, 0, 1'b0, 1'b0, "R9");

    // Window contents unchanged by the ignored cycles.
    for (int i = 0; i < WIN_N; i++)
      io_txn(4'h0, 4'h0, cfg_base + 16'(i), 8'h00, 0, 1'b0, 1'b1, "R8");

    // Abort during a long wait.
    tb_wait = 6; tb_err = 1'b0;
    hcyc(1'b0, 4'h0);
    hcyc(1'b1, 4'h0);
    for (int i = 3; i >= 0; i--) hcyc(1'b1, 16'(cfg_base + 16'd2) >> (i * 4));
    hcyc(1'b1, 4'hF);
    host_drv = 1'b0;
    @(negedge clk);
    #1 chk(nib_oe && bus == 4'h6, "R5", {11'd0, nib_oe, bus}, 16'h0016);
    @(negedge clk);
    hcyc(1'b0, 4'hF);
    #1 chk(!nib_oe, "R10", 16'(nib_oe), 16'h0);
    for (int k = 0; k < 3; k++) hcyc(1'b0, 4'hF);
    hcyc(1'b1, 4'hF);
    host_drv = 1'b0;
    for (int k = 0; k < 8; k++) begin
      #1 chk(!nib_oe && !loc_wr && !loc_rd, "R10", {13'd0, nib_oe, loc_wr, loc_rd}, 16'h0);
      @(negedge clk);
    end
    io_txn(4'h0, 4'h0, cfg_base + 16'd2, 8'h00, 1, 1'b0, 1'b1, "R10");

    // Window at the top of the I/O space.
    cfg_base = 16'hFFF8;
    @(negedge clk);
    io_txn(4'h0, 4'h2, 16'hFFFF, 8'hC7, 2, 1'b0, 1'b1, "R2");
    io_txn(4'h0, 4'h0, 16'hFFFF, 8'h00, 0, 1'b0, 1'b1, "R2");
    io_txn(4'h0, 4'h0, 16'hFFF8, 8'h00, 0, 1'b1, 1'b1, "R5");
    io_txn(4'h0, 4'h2, 16'hFFF7, 8'h99, 0, 1'b0, 1'b0, "R8");
    io_txn(4'h0, 4'h0, 16'h0007, 8'h00, 0, 1'b0, 1'b0, "R8");
    io_txn(4'h0, 4'h0, 16'hFFF7 + 16'd0, 8'h00, 0, 1'b0, 1'b0, "R8");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule